// File: doc/BRIEF.md
# JTAG-to-SPI Flash Bridge

This block lets a host program a serial flash through a JTAG chain. When a user instruction selects it and the TAP is shifting the data register, the block watches the incoming TDI stream. It skips any zero bits that bypassed devices ahead of it push through. The first one bit is a start marker. The next 32 bits, most significant bit first, give the transfer length in SPI clock cycles. The block then asserts the flash chip select for exactly that many TCK cycles. During that time TDI drives MOSI, the gated TCK drives the SPI clock, and MISO is returned on TDO.

Outside the transfer window the block behaves like a one-bit bypass register. The host can therefore keep shifting after the transfer so that returned data passes through the devices that follow it in the chain. The round-trip delay seen by the host equals the number of enabled TAPs. Leaving Shift-DR, a TAP reset or deselecting the instruction cancels a transfer at any point.

Top module: `jtag_spi_bridge`

## Requirements
- R1: After the synchronous active-low reset, cs_n is 1, spi_clk is 0 and tdo is 0.
- R2: The bridge acts only while insn_sel is 1, shift_dr is 1 and tap_reset is 0. Under any other input combination cs_n stays 1 and spi_clk stays 0, even when the stream carries a marker and a length.
- R3: Zero bits at the start of a shift are ignored. The first TDI bit equal to 1 is the marker.
- R4: The 32 bits after the marker are the length N, most significant bit first. cs_n goes low after the rising TCK edge that takes the last length bit and goes high after the N-th following rising edge.
- R5: While cs_n is low, mosi follows tdi. The flash sees, on its N rising spi_clk edges, the N TDI bits that follow the length field.
- R6: On each of the N payload edges, the block samples miso on the rising TCK edge and presents it on tdo until the next rising edge.
- R7: Outside the payload edges, tdo shows the TDI bit taken at the previous rising edge (a one-bit register). Capture-DR with insn_sel set clears this register to 0.
- R8: After a completed transfer, further shift bits, including ones, do not assert cs_n again until Shift-DR is left.
- R9: If shift_dr falls, tap_reset rises or insn_sel falls during a transfer, cs_n goes high at once, no further spi_clk edge occurs, and the next shift hunts for a new marker.
- R10: A length of zero ends the frame without asserting cs_n or pulsing spi_clk.
- R11: spi_clk has a rising edge only on the TCK rising edges of the payload. It has exactly N rising edges per frame, never an extra one when cs_n falls, and it is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock; also the source of the SPI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_sel | input | 1 | User instruction currently selected in the TAP |
| shift_dr | input | 1 | TAP is in Shift-DR |
| capture_dr | input | 1 | TAP is in Capture-DR |
| tap_reset | input | 1 | TAP is in Test-Logic-Reset |
| tdi | input | 1 | JTAG serial data in |
| miso | input | 1 | Serial data from the flash |
| tdo | output | 1 | JTAG serial data out |
| spi_clk | output | 1 | Gated SPI clock to the flash |
| mosi | output | 1 | Serial data to the flash |
| cs_n | output | 1 | Active-low flash chip select |

## Verification
A wrong phase or length count shows up at the ports within one TCK cycle. cs_n falls or rises one cycle off the computed window, or it never releases. A wrong number of spi_clk pulses follows. Bit-order or marker errors push the window far from where the bench expects it, so the per-bit window comparison flags them in the frame where they happen. A broken data path shows as tdo disagreeing with the miso or tdi bit of the previous rising edge. A broken abort shows as cs_n still low just after the controlling input drops.

// File: rtl/jsb_pkg.sv
// Shared types for the JTAG-to-SPI bridge.
// Assumes: one clock domain (TCK); phase order matches a frame's life.
package jsb_pkg;
    typedef enum logic [1:0] {
        PH_HUNT = 2'd0,  // waiting for the start marker
        PH_LEN  = 2'd1,  // shifting in the length field
        PH_XFER = 2'd2,  // chip select asserted, payload running
        PH_DONE = 2'd3   // payload finished, bits only ripple through
    } jsb_phase_e;
endpackage

// File: rtl/jsb_len_counter.sv
// Length register and field-bit index for the bridge.
// It shifts the length in MSB first during PH_LEN and counts it down during PH_XFER.
// Assumes: LEN_W >= 2; the state is cleared whenever the bridge is inactive.
module jsb_len_counter
    import jsb_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tdi,
    input  jsb_phase_e       phase,
    output logic             len_done,
    output logic             len_zero,
    output logic             cnt_last,
    output logic [LEN_W-1:0] cnt
);
    localparam int IDX_W = $clog2(LEN_W);

    logic [IDX_W-1:0] idx;
    logic [LEN_W-1:0] shifted;

    // Value the length register takes if the current TDI bit is shifted in
    assign shifted  = {cnt[LEN_W-2:0], tdi};
    assign len_done = (phase == PH_LEN) && (idx == IDX_W'(LEN_W - 1));
    assign len_zero = (shifted == '0);
    assign cnt_last = (cnt == LEN_W'(1));

    // Load the length one bit per TCK, then count the payload down
    always_ff @(posedge tck) begin
        if (!rst_n || !active) begin
            idx <= '0;
            cnt <= '0;
        end else begin
            case (phase)
                PH_HUNT: begin
                    idx <= '0;
                    cnt <= '0;
                end
                PH_LEN: begin
                    cnt <= shifted;
                    idx <= idx + 1'b1;
                end
                PH_XFER: cnt <= cnt - 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/jsb_frame_fsm.sv
// Frame sequencer: marker hunt, length field, payload, then trailing bits.
// Assumes: "active" already combines instruction select, Shift-DR and TAP reset.
module jsb_frame_fsm
    import jsb_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       active,
    input  logic       tdi,
    input  logic       len_done,
    input  logic       len_zero,
    input  logic       cnt_last,
    output jsb_phase_e phase
);
    jsb_phase_e nxt;

    // Next phase: any loss of activity sends the sequencer back to the hunt
    always_comb begin
        nxt = phase;
        if (!active) begin
            nxt = PH_HUNT;
        end else begin
            case (phase)
                PH_HUNT: if (tdi) nxt = PH_LEN;
                PH_LEN:  if (len_done) nxt = len_zero ? PH_DONE : PH_XFER;
                PH_XFER: if (cnt_last) nxt = PH_DONE;
                default: nxt = PH_DONE;
            endcase
        end
    end

    // Phase register
    always_ff @(posedge tck) begin
        if (!rst_n) phase <= PH_HUNT;
        else        phase <= nxt;
    end
endmodule

// File: rtl/jsb_route.sv
// Signal routing: the one-bit data register, chip select, SPI clock gate and data paths.
// Assumes: the flash samples MOSI on the rising SPI clock edge (mode 0); the host
// changes TDI on falling TCK.
module jsb_route
    import jsb_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       insn_sel,
    input  logic       capture_dr,
    input  logic       tap_reset,
    input  logic       active,
    input  jsb_phase_e phase,
    input  logic       tdi,
    input  logic       miso,
    output logic       tdo,
    output logic       spi_clk,
    output logic       mosi,
    output logic       cs_n
);
    logic xfer;
    logic dr_q;
    logic gate_q;

    assign xfer    = (phase == PH_XFER) && active;
    assign cs_n    = ~xfer;
    assign mosi    = tdi;
    assign tdo     = dr_q;
    // The gate opens only at a falling edge, so cs_n falling never makes an edge;
    // the active term stops the clock as soon as a transfer is aborted
    assign spi_clk = tck & gate_q & active;

    // One-bit data register: takes MISO in the payload and TDI otherwise
    always_ff @(posedge tck) begin
        if (!rst_n || tap_reset)         dr_q <= 1'b0;
        else if (insn_sel && capture_dr) dr_q <= 1'b0;
        else if (active)                 dr_q <= xfer ? miso : tdi;
    end

    // Clock-gate enable, updated while TCK is low
    always_ff @(negedge tck) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= xfer;
    end
endmodule

// File: rtl/jtag_spi_bridge.sv
// Top level of the JTAG-to-SPI flash bridge.
// It joins the frame sequencer, the length counter and the routing.
// Assumes: the TAP controller outside provides the state indications in the TCK domain.
module jtag_spi_bridge
    import jsb_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic tck,
    input  logic rst_n,
    input  logic insn_sel,
    input  logic shift_dr,
    input  logic capture_dr,
    input  logic tap_reset,
    input  logic tdi,
    input  logic miso,
    output logic tdo,
    output logic spi_clk,
    output logic mosi,
    output logic cs_n
);
    logic             active;
    logic             len_done;
    logic             len_zero;
    logic             cnt_last;
    logic [LEN_W-1:0] cnt;
    jsb_phase_e       phase;

    assign active = insn_sel & shift_dr & ~tap_reset;

    jsb_frame_fsm u_fsm (
        .tck      (tck),
        .rst_n    (rst_n),
        .active   (active),
        .tdi      (tdi),
        .len_done (len_done),
        .len_zero (len_zero),
        .cnt_last (cnt_last),
        .phase    (phase)
    );

    jsb_len_counter #(.LEN_W(LEN_W)) u_cnt (
        .tck      (tck),
        .rst_n    (rst_n),
        .active   (active),
        .tdi      (tdi),
        .phase    (phase),
        .len_done (len_done),
        .len_zero (len_zero),
        .cnt_last (cnt_last),
        .cnt      (cnt)
    );

    jsb_route u_route (
        .tck        (tck),
        .rst_n      (rst_n),
        .insn_sel   (insn_sel),
        .capture_dr (capture_dr),
        .tap_reset  (tap_reset),
        .active     (active),
        .phase      (phase),
        .tdi        (tdi),
        .miso       (miso),
        .tdo        (tdo),
        .spi_clk    (spi_clk),
        .mosi       (mosi),
        .cs_n       (cs_n)
    );
endmodule

// File: rtl/jsb_checker.sv
// Property checker for jtag_spi_bridge, attached with bind.
// Assumes: sampling on rising TCK, with reset as the disable condition.
module jsb_checker
    import jsb_pkg::*;
(
    input logic       tck,
    input logic       rst_n,
    input logic       active,
    input logic       cs_n,
    input logic       tdo,
    input logic       miso,
    input logic       len_done,
    input logic       len_zero,
    input jsb_phase_e phase
);
    // R2: inactive bridge never selects the flash
    a_r2_idle_cs_high: assert property (@(posedge tck) disable iff (!rst_n)
        !active |-> cs_n);

    // R4: chip select only falls right after the length field
    a_r4_cs_after_len: assert property (@(posedge tck) disable iff (!rst_n)
        $fell(cs_n) |-> ($past(phase) == PH_LEN));

    // R6: a payload edge puts the sampled MISO bit on TDO
    a_r6_miso_to_tdo: assert property (@(posedge tck) disable iff (!rst_n)
        $past(phase == PH_XFER && active) |-> (tdo == $past(miso)));

    // R9: any loss of activity returns the sequencer to the hunt
    a_r9_abort_hunt: assert property (@(posedge tck) disable iff (!rst_n)
        !active |=> (phase == PH_HUNT));

    // R10: a zero length skips the payload phase
    a_r10_zero_skip: assert property (@(posedge tck) disable iff (!rst_n)
        (active && len_done && len_zero) |=> (phase == PH_DONE));
endmodule

bind jtag_spi_bridge jsb_checker u_chk (
    .tck      (tck),
    .rst_n    (rst_n),
    .active   (active),
    .cs_n     (cs_n),
    .tdo      (tdo),
    .miso     (miso),
    .len_done (len_done),
    .len_zero (len_zero),
    .phase    (phase)
);

// File: tb/sim_jtag_spi_bridge.sv
`timescale 1ns/1ps
// Bench for jtag_spi_bridge: sweeps frames over lengths and leading-zero counts.
// Expected windows and data are computed from the bit index.
module sim_jtag_spi_bridge;
    logic tck = 1'b0;
    logic rst_n = 1'b0;
    logic insn_sel = 1'b0, shift_dr = 1'b0, capture_dr = 1'b0, tap_reset = 1'b0;
    logic tdi = 1'b0, miso = 1'b0;
    logic tdo, spi_clk, mosi, cs_n;
    int   n_chk = 0, n_fail = 0;
    bit   finished = 1'b0;

    always #2.5 tck = ~tck;

    jtag_spi_bridge u0 (
        .tck(tck), .rst_n(rst_n), .insn_sel(insn_sel), .shift_dr(shift_dr),
        .capture_dr(capture_dr), .tap_reset(tap_reset), .tdi(tdi), .miso(miso),
        .tdo(tdo), .spi_clk(spi_clk), .mosi(mosi), .cs_n(cs_n)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One full frame: capture, z zeros, marker, 32-bit length n, payload, t trailing bits
    task automatic run_frame(input int z, input int n, input int t, input int seed);
        int L = z + 32;
        int total = z + 33 + n + t;
        int e_cs = 0, e_clk = 0, e_mosi = 0, e_pay = 0, e_out = 0, edges = 0;
        logic [31:0] nv = n;
        @(negedge tck); insn_sel = 1'b1; shift_dr = 1'b0; capture_dr = 1'b1;
        @(posedge tck); #1;
        check(tdo == 1'b0, "R7 capture clears tdo", tdo, 0);
        for (int j = 0; j < total; j++) begin
            logic b, m, exp_low, exp_clk;
            if (j < z) b = 1'b0;
            else if (j == z) b = 1'b1;
            else if (j <= L) b = nv[31 - (j - z - 1)];
            else if (j <= L + n) b = (((j * 5 + seed) % 3) == 0);
            else b = j[0];
            m = (((j * 3 + seed) % 4) < 2);
            @(negedge tck); capture_dr = 1'b0; shift_dr = 1'b1; tdi = b; miso = m;
            @(posedge tck); #1;
            exp_low = (n > 0) && (j >= L) && (j <= L + n - 1);
            exp_clk = (n > 0) && (j >= L + 1) && (j <= L + n);
            if (cs_n != !exp_low) e_cs++;
            if (spi_clk != exp_clk) e_clk++;
            if (spi_clk) edges++;
            if (exp_clk && mosi != b) e_mosi++;
            if (exp_clk && tdo != m) e_pay++;
            if (!exp_clk && tdo != b) e_out++;
        end
        @(negedge tck); shift_dr = 1'b0; tdi = 1'b0;
        if (n == 0) check(e_cs == 0, "R10 zero length keeps cs_n high", e_cs, 0);
        else        check(e_cs == 0, "R3 R4 R8 cs_n window", e_cs, 0);
        check(edges == n, "R4 spi_clk edge count", edges, n);
        check(e_clk == 0, "R11 spi_clk only on payload edges", e_clk, 0);
        check(e_mosi == 0, "R5 mosi at spi edges", e_mosi, 0);
        check(e_pay == 0, "R6 tdo carries miso", e_pay, 0);
        check(e_out == 0, "R7 tdo one-bit delay", e_out, 0);
    endtask

    // Start a long frame, abort it after k payload bits with the given kind, then recover
    task automatic abort_test(input int kind, input int k);
        logic [31:0] nv = 32'd40;
        @(negedge tck); insn_sel = 1'b1; shift_dr = 1'b1; tdi = 1'b1;
        for (int j = 0; j < 32 + k; j++) begin
            @(negedge tck); tdi = (j < 32) ? nv[31 - j] : j[0];
        end
        @(posedge tck); #1;
        check(cs_n == 1'b0, "R9 transfer running before abort", cs_n, 0);
        @(negedge tck);
        if (kind == 0) shift_dr = 1'b0;
        else if (kind == 1) tap_reset = 1'b1;
        else insn_sel = 1'b0;
        #1;
        check(cs_n == 1'b1, "R9 cs_n released on abort", cs_n, 1);
        @(posedge tck); #1;
        check(cs_n == 1'b1 && spi_clk == 1'b0, "R9 no spi_clk after abort", spi_clk, 0);
        @(negedge tck); tap_reset = 1'b0; insn_sel = 1'b1; shift_dr = 1'b0;
        run_frame(2, 4, 3, kind + 11);
    endtask

    initial begin
        int bad;
        repeat (3) @(posedge tck);
        @(negedge tck); rst_n = 1'b1;
        @(posedge tck); #1;
        check(cs_n == 1'b1, "R1 reset cs_n", cs_n, 1);
        check(spi_clk == 1'b0, "R1 reset spi_clk", spi_clk, 0);
        check(tdo == 1'b0, "R1 reset tdo", tdo, 0);

        // R2: a full frame while the instruction is not selected
        bad = 0;
        @(negedge tck); insn_sel = 1'b0; shift_dr = 1'b1;
        for (int j = 0; j < 50; j++) begin
            @(negedge tck); tdi = (j == 0) || (j == 31) || (j == 33) || (j > 33);
            @(posedge tck); #1;
            if (cs_n != 1'b1 || spi_clk != 1'b0) bad++;
        end
        @(negedge tck); shift_dr = 1'b0; tdi = 1'b0;
        check(bad == 0, "R2 deselected stream ignored", bad, 0);

        // R3 R4 sweep over short lengths with and without leading zeros
        for (int n = 0; n <= 12; n++) begin
            run_frame(0, n, 5, n);
            run_frame(3, n, 6, n + 7);
        end
        run_frame(5, 257, 4, 3);   // R4 MSB-first multi-byte length

        abort_test(0, 5);          // R9 leave Shift-DR
        abort_test(1, 2);          // R9 TAP reset
        abort_test(2, 9);          // R9 instruction deselected

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule